// File: doc/BRIEF.md
# Feed-Committed PLL Control Registers

This block holds the control and configuration settings of an on-chip PLL behind a two-stage register scheme. Software writes land in staging registers. They are copied into the active registers only when an unlock pair of writes arrives on a dedicated feed address. Both staged registers move to the active set in one clock cycle. From the active set the block drives the PLL enable, a 5-bit multiplier code and a 2-bit divider code. It also drives the connect decision, which selects the PLL output as the system clock.

The connect decision feeds a glitch-free clock switch. The switch moves the system clock between the oscillator (the bus clock) and the PLL output. The lock indicator from the analog PLL is an input. It can be read back, but it never gates the connection: the block neither waits for lock nor drops the PLL when lock goes away.

The bus is a single-cycle write port and a read port whose data is registered. Status addresses show what is actually in effect.

Top module: `pll_cfg_regs`

## Requirements
- R1: After reset the staged and active settings are all zero, so enable, connect, multiplier and divider outputs are 0. The system clock follows the oscillator.
- R2: The control register sits at address 0, with enable in bit 0 and connect in bit 1. The configuration register sits at address 1, with the multiplier in bits 4:0 and the divider in bits 6:5. Reading either address returns the staged value, with every reserved bit read as 0.
- R3: A write to address 0 or 1 leaves the PLL outputs unchanged until a valid feed commits it.
- R4: A valid feed is a write of 0xAA to address 3 whose next bus access is a write of 0x55 to address 3. Idle cycles between the two are allowed. The 0x55 write copies both staged registers to the outputs together, visible after the clock edge that takes it.
- R5: Any other bus access between the 0xAA and the 0x55 aborts the feed. That includes a read, a write to another address, or a different value to address 3. The following 0x55 then commits nothing.
- R6: The connect output is 1 exactly when the committed enable and connect bits are both 1. It does not depend on the lock input, and it stays 1 while lock changes.
- R7: Address 4 reads the active enable in bit 0, the active connect bit in bit 1 and the lock input in bit 2. Address 5 reads the active multiplier in bits 4:0 and the active divider in bits 6:5.
- R8: The system clock output never has both source gates open at once. After connect rises it follows the PLL clock, and after connect falls it follows the oscillator again.
- R9: A read presents its data on the read port after the clock edge that takes it. Addresses 2, 3, 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator / bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pll_clk_i | input | 1 | PLL output clock |
| lock_i | input | 1 | PLL lock indicator |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pll_en_o | output | 1 | Committed PLL enable |
| pll_mul_o | output | 5 | Committed multiplier code |
| pll_div_o | output | 2 | Committed divider code |
| pll_conn_o | output | 1 | Committed connect (enable and connect) |
| clk_o | output | 1 | Glitch-free selected system clock |

## Verification
The assertions assume that a bus cycle carries at most one of write and read. They also assume that successive changes of the connect decision are spaced by many cycles of the slower clock, so each handover between the two clock gates completes before the next one starts. The stimulus drives one access or an idle per cycle and never strobes write and read together. It waits tens of cycles after every commit that changes the connect decision before it issues another one. The PLL clock runs free from time zero, so both synchronizer chains leave reset under a running clock.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    localparam int DATA_W = 8;
    localparam int MUL_W  = 5;
    localparam int DIV_W  = 2;
    localparam int CFG_W  = MUL_W + DIV_W;

    localparam int A_CTRL     = 0;
    localparam int A_CFG      = 1;
    localparam int A_FEED     = 3;
    localparam int A_STAT_CTL = 4;
    localparam int A_STAT_CFG = 5;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;

    typedef struct packed {
        logic conn;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [MUL_W-1:0] mul;
    } cfg_t;

endpackage

// File: rtl/pll_feed_unlock.sv
module pll_feed_unlock
    import pll_cfg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              access_i,
    input  logic              feed_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              commit_o
);

    typedef struct packed {
        logic armed;
    } feed_t;

    feed_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        commit_o = 1'b0;
        if (access_i) begin
            commit_o = st_q.armed && feed_wr_i && (wdata_i == KEY_SECOND);
            st_d.armed = feed_wr_i && (wdata_i == KEY_FIRST);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pll_reg_bank.sv
module pll_reg_bank
    import pll_cfg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              commit_i,
    input  logic              lock_i,
    output logic [DATA_W-1:0] rdata_o,
    output ctrl_t             act_ctrl_o,
    output cfg_t              act_cfg_o
);

    typedef struct packed {
        ctrl_t             stg_ctrl;
        cfg_t              stg_cfg;
        ctrl_t             act_ctrl;
        cfg_t              act_cfg;
        logic [DATA_W-1:0] rdata;
    } bank_t;

    bank_t st_d, st_q;

    logic unused_bits;
    assign unused_bits = &{1'b0, wdata_i[DATA_W-1:CFG_W]};

    always_comb begin
        st_d = st_q;
        if (wr_en_i && addr_i == ADDR_W'(A_CTRL)) begin
            st_d.stg_ctrl = ctrl_t'(wdata_i[1:0]);
        end
        if (wr_en_i && addr_i == ADDR_W'(A_CFG)) begin
            st_d.stg_cfg = cfg_t'(wdata_i[CFG_W-1:0]);
        end
        if (commit_i) begin
            st_d.act_ctrl = st_q.stg_ctrl;
            st_d.act_cfg  = st_q.stg_cfg;
        end
        if (rd_en_i) begin
            case (addr_i)
                ADDR_W'(A_CTRL):     st_d.rdata = DATA_W'(st_q.stg_ctrl);
                ADDR_W'(A_CFG):      st_d.rdata = DATA_W'(st_q.stg_cfg);
                ADDR_W'(A_STAT_CTL): st_d.rdata = DATA_W'({lock_i, st_q.act_ctrl});
                ADDR_W'(A_STAT_CFG): st_d.rdata = DATA_W'(st_q.act_cfg);
                default:             st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o    = st_q.rdata;
    assign act_ctrl_o = st_q.act_ctrl;
    assign act_cfg_o  = st_q.act_cfg;

endmodule

// File: rtl/pll_clk_switch.sv
module pll_clk_switch #(
    parameter int SYNC_N = 2
) (
    input  logic clk_osc_i,
    input  logic clk_pll_i,
    input  logic rst_ni,
    input  logic sel_pll_i,
    output logic osc_gate_o,
    output logic pll_gate_o,
    output logic clk_o
);

    localparam int LAST = SYNC_N - 1;

    logic [LAST:0] osc_sync_q;
    logic [LAST:0] pll_sync_q;
    logic          osc_gate_q;
    logic          pll_gate_q;
    logic          osc_req;
    logic          pll_req;

    assign osc_req = !sel_pll_i && !pll_gate_q;
    assign pll_req =  sel_pll_i && !osc_gate_q;

    // oscillator side: sync on rising edge, gate update on falling edge
    always_ff @(posedge clk_osc_i or negedge rst_ni) begin
        if (!rst_ni) begin
            osc_sync_q <= '1;
        end else begin
            osc_sync_q <= {osc_sync_q[LAST-1:0], osc_req};
        end
    end

    always_ff @(negedge clk_osc_i or negedge rst_ni) begin
        if (!rst_ni) begin
            osc_gate_q <= 1'b1;
        end else begin
            osc_gate_q <= osc_sync_q[LAST];
        end
    end

    // PLL side: same structure in the PLL clock domain
    always_ff @(posedge clk_pll_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pll_sync_q <= '0;
        end else begin
            pll_sync_q <= {pll_sync_q[LAST-1:0], pll_req};
        end
    end

    always_ff @(negedge clk_pll_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pll_gate_q <= 1'b0;
        end else begin
            pll_gate_q <= pll_sync_q[LAST];
        end
    end

    assign osc_gate_o = osc_gate_q;
    assign pll_gate_o = pll_gate_q;
    assign clk_o      = (clk_osc_i & osc_gate_q) | (clk_pll_i & pll_gate_q);

endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
    import pll_cfg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pll_clk_i,
    input  logic              lock_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              pll_en_o,
    output logic [MUL_W-1:0]  pll_mul_o,
    output logic [DIV_W-1:0]  pll_div_o,
    output logic              pll_conn_o,
    output logic              clk_o
);

    logic  commit_w;
    logic  feed_wr_w;
    logic  access_w;
    ctrl_t act_ctrl_w;
    cfg_t  act_cfg_w;
    logic  sel_pll_w;
    logic  osc_gate_w;
    logic  pll_gate_w;

    assign access_w  = wr_en_i | rd_en_i;
    assign feed_wr_w = wr_en_i && (addr_i == ADDR_W'(A_FEED));

    pll_feed_unlock u_feed (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .access_i (access_w),
        .feed_wr_i(feed_wr_w),
        .wdata_i  (wdata_i),
        .commit_o (commit_w)
    );

    pll_reg_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .commit_i  (commit_w),
        .lock_i    (lock_i),
        .rdata_o   (rdata_o),
        .act_ctrl_o(act_ctrl_w),
        .act_cfg_o (act_cfg_w)
    );

    assign sel_pll_w = act_ctrl_w.en & act_ctrl_w.conn;

    pll_clk_switch #(.SYNC_N(SYNC_N)) u_sw (
        .clk_osc_i (clk_i),
        .clk_pll_i (pll_clk_i),
        .rst_ni    (rst_ni),
        .sel_pll_i (sel_pll_w),
        .osc_gate_o(osc_gate_w),
        .pll_gate_o(pll_gate_w),
        .clk_o     (clk_o)
    );

    assign pll_en_o   = act_ctrl_w.en;
    assign pll_mul_o  = act_cfg_w.mul;
    assign pll_div_o  = act_cfg_w.div;
    assign pll_conn_o = sel_pll_w;

endmodule

// File: rtl/pll_cfg_regs_chk.sv
module pll_cfg_regs_chk
    import pll_cfg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              pll_en_o,
    input logic [MUL_W-1:0]  pll_mul_o,
    input logic [DIV_W-1:0]  pll_div_o,
    input logic              pll_conn_o,
    input logic              commit_w,
    input logic              osc_gate_w,
    input logic              pll_gate_w
);

    logic non_first_key;
    assign non_first_key = rd_en_i ||
        (wr_en_i && !(addr_i == ADDR_W'(A_FEED) && wdata_i == KEY_FIRST));

    // R3: without a commit the outputs hold
    a_r3_outputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_w |=> $stable({pll_en_o, pll_conn_o, pll_mul_o, pll_div_o}));

    // R4: a commit only happens on a second-key write to the feed address
    a_r4_commit_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_w |-> (wr_en_i && addr_i == ADDR_W'(A_FEED) && wdata_i == KEY_SECOND));

    // R5: any access other than a first-key write disarms the feed
    a_r5_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
        non_first_key |=> !commit_w);

    // R6: connection holds regardless of lock until a new commit
    a_r6_no_auto_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pll_conn_o && !commit_w) |=> pll_conn_o);

    // R8: the two clock gates are never open together
    a_r8_gates_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(osc_gate_w && pll_gate_w));

    // R2: reserved control bits read as zero
    a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == ADDR_W'(A_CTRL)) |=> (rdata_o[DATA_W-1:2] == '0));

endmodule

bind pll_cfg_regs pll_cfg_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pll_en_o  (pll_en_o),
    .pll_mul_o (pll_mul_o),
    .pll_div_o (pll_div_o),
    .pll_conn_o(pll_conn_o),
    .commit_w  (commit_w),
    .osc_gate_w(osc_gate_w),
    .pll_gate_w(pll_gate_w)
);

// File: tb/sim_pll_cfg_regs.sv
`timescale 1ns/1ps
module sim_pll_cfg_regs;

    logic       clk = 1'b0;
    logic       pll_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lock = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pll_en;
    logic [4:0] pll_mul;
    logic [1:0] pll_div;
    logic       pll_conn;
    logic       clk_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string req;
        int    kind;
        int    val;
    } item_t;

    item_t exp_q[$];

    always #2 clk = ~clk;
    initial begin
        #1;
        forever #3 pll_clk = ~pll_clk;
    end

    pll_cfg_regs u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pll_clk_i (pll_clk),
        .lock_i    (lock),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .pll_en_o  (pll_en),
        .pll_mul_o (pll_mul),
        .pll_div_o (pll_div),
        .pll_conn_o(pll_conn),
        .clk_o     (clk_out)
    );

    function automatic int outv();
        return int'({pll_conn, pll_en, pll_div, pll_mul});
    endfunction

    function automatic int pack_exp(input bit en, input bit conn, input int div, input int mul);
        return ((en && conn) ? 256 : 0) + (en ? 128 : 0) + (div * 32) + mul;
    endfunction

    function automatic void chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endfunction

    task automatic acc(input bit w, input bit r, input int a, input int d);
        @(negedge clk);
        wr_en = w;
        rd_en = r;
        addr  = 3'(a);
        wdata = 8'(d);
    endtask

    task automatic idle();
        acc(0, 0, 0, 0);
    endtask

    task automatic exp_out(input string req, input int v);
        item_t it;
        it.req = req; it.kind = 0; it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic exp_rd(input string req, input int v);
        item_t it;
        it.req = req; it.kind = 1; it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic follow_pll(input string req);
        for (int i = 0; i < 4; i++) begin
            @(posedge pll_clk); #0.5; chk(req, int'(clk_out), 1);
            @(negedge pll_clk); #0.5; chk(req, int'(clk_out), 0);
        end
    endtask

    task automatic follow_osc(input string req);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #0.5; chk(req, int'(clk_out), 1);
            @(negedge clk); #0.5; chk(req, int'(clk_out), 0);
        end
    endtask

    // monitor: compares queued expectations just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                if (it.kind == 0) chk(it.req, outv(), it.val);
                else              chk(it.req, int'(rdata), it.val);
            end
        end
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle(); exp_out("R1 reset outputs", 0);
        acc(0, 1, 0, 0); exp_rd("R1 reset staged ctrl", 0);
        idle();
        follow_osc("R1 osc after reset");

        // R2/R3: staged writes with reserved bits set
        acc(1, 0, 0, 8'hFF); exp_out("R3 ctrl write held", 0);
        acc(1, 0, 1, 8'hD1); exp_out("R3 cfg write held", 0);
        acc(0, 1, 0, 0);     exp_rd("R2 ctrl readback", 8'h03);
        acc(0, 1, 1, 0);     exp_rd("R2 cfg readback", 8'h51);
        acc(0, 1, 4, 0);     exp_rd("R3 status unchanged", 0);

        // R5: aborted feeds
        acc(1, 0, 3, 8'hAA); acc(0, 1, 2, 0); exp_rd("R9 unmapped addr 2", 0);
        acc(1, 0, 3, 8'h55); exp_out("R5 read between keys", 0);
        acc(1, 0, 3, 8'hAA); acc(1, 0, 1, 8'h51);
        acc(1, 0, 3, 8'h55); exp_out("R5 write between keys", 0);
        acc(1, 0, 3, 8'hAA); acc(1, 0, 3, 8'h56);
        acc(1, 0, 3, 8'h55); exp_out("R5 wrong second key", 0);
        idle();

        // R4: valid feed with idle gap commits both registers together
        acc(1, 0, 3, 8'hAA); idle(); idle();
        acc(1, 0, 3, 8'h55); exp_out("R4 commit both", pack_exp(1, 1, 2, 5'h11));
        acc(0, 1, 4, 0);     exp_rd("R6 status conn without lock", 8'h03);
        acc(0, 1, 5, 0);     exp_rd("R7 status cfg", 8'h51);
        idle();
        repeat (30) @(posedge clk);
        follow_pll("R8 follows pll");

        // R6: lock toggles do not change connection
        @(negedge clk); lock = 1'b1;
        acc(0, 1, 4, 0);     exp_rd("R7 status with lock", 8'h07);
        idle(); lock = 1'b0; exp_out("R6 lock lost keeps conn", pack_exp(1, 1, 2, 5'h11));
        idle();

        // R6: enable only -> disconnect, back to oscillator
        acc(1, 0, 0, 8'h01); acc(1, 0, 1, 8'h27);
        acc(1, 0, 3, 8'hAA);
        acc(1, 0, 3, 8'h55); exp_out("R6 enable only no conn", pack_exp(1, 0, 1, 5'h07));
        idle();
        repeat (30) @(posedge clk);
        follow_osc("R8 back to osc");

        // R6: connect without enable stays disconnected
        acc(1, 0, 0, 8'h02);
        acc(1, 0, 3, 8'hAA);
        acc(1, 0, 3, 8'h55); exp_out("R6 conn only no conn", pack_exp(0, 1, 1, 5'h07));
        acc(0, 1, 4, 0);     exp_rd("R7 status conn only", 8'h02);
        acc(0, 1, 6, 0);     exp_rd("R9 unmapped addr 6", 0);
        acc(0, 1, 3, 0);     exp_rd("R9 feed addr reads 0", 0);
        idle(); idle(); idle();
        follow_osc("R8 osc held");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule